// File: doc/BRIEF.md
# CPU Idle Phase Sequencer

This block runs one processor core through its low-power cycle. After reset the core executes normally. When the core asks to go idle it names a target state. The sequencer then walks the core through the steps that state needs:

- an optional preparation step, which can be cancelled;
- a committed entry step of fixed length;
- the idle step itself;
- an exit step of fixed length.

When the exit step ends, the core runs again. Each state has its own entry length, exit length and abortable flag. These sit in a small table that software loads through a write port.

The preparation step stands for work such as flushing caches. The sequencer raises `flush_req` during this step and waits for `prep_done`. A wake-up during preparation cancels the sequence, and the core goes straight back to execution. Once entry has begun it cannot be stopped. A wake-up that arrives during entry is remembered. Idle is then skipped and exit starts at once, so the exit timing is counted from the end of entry. Power switching is not done here: the block only gives out strobes for power-off and power-on.

The idle request is a valid/ready handshake. `req_ready` is high only while the core is executing. The requester keeps `req_valid` and `req_state` steady until it sees `req_ready` high at a rising edge. While `req_ready` is low, the request has no effect.

Top module: `cpu_idle_sequencer`

## Requirements
- R1: After reset `phase` is 0 (execute), `req_ready` is 1, and `committed`, `flush_req`, `abort_pulse`, `resume_pulse`, `pwr_off_strobe` and `pwr_on_strobe` are all 0.
- R2: A request is taken only at an edge where `phase` is execute and `req_valid` is 1. In every other phase `req_ready` is 0, and a request there leaves the phase unchanged.
- R3: A taken request moves to preparation (`phase` 1, `flush_req` 1) if the selected state's abortable flag is 1. If the flag is 0, it moves straight to entry (`phase` 2).
- R4: In preparation, a sampled `wake` returns to execute at the next edge, with `abort_pulse` high for exactly that first execute cycle. This holds even when `prep_done` is high in the same cycle. A `prep_done` without `wake` moves to entry.
- R5: Entry lasts max(E,1) cycles, where E is the entry count of the selected state. `wake` never ends entry early.
- R6: If `wake` is sampled in any entry cycle, idle (`phase` 3) is skipped and the cycle after entry is already exit (`phase` 4).
- R7: Idle holds until `wake` is sampled. Exit then begins at the next edge.
- R8: Exit lasts max(X,1) cycles, where X is the exit count, and `wake` is ignored during it. Exit is followed by execute, with `resume_pulse` high only in that first execute cycle.
- R9: `committed` is 1 exactly in entry, idle and exit.
- R10: `pwr_off_strobe` is high for the single cycle after entry ends. `pwr_on_strobe` is high for the first exit cycle.
- R11: The entry and exit counts are captured when the request is taken. A table write later in the sequence does not change its timing.
- R12: Phase codes are execute 0, preparation 1, entry 2, idle 3, exit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Idle request valid |
| req_ready | output | 1 | Request can be taken (core executing) |
| req_state | input | IDX_W | Target state index |
| wake | input | 1 | Wake-up event, sampled every cycle |
| prep_done | input | 1 | Preparation work finished |
| cfg_wr | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_entry | input | CNT_W | Entry length in cycles |
| cfg_exit | input | CNT_W | Exit length in cycles |
| cfg_abortable | input | 1 | State uses an abortable preparation step |
| phase | output | 3 | Current phase code |
| committed | output | 1 | Core is committed to the low-power cycle |
| flush_req | output | 1 | Preparation work requested |
| abort_pulse | output | 1 | One-cycle pulse on preparation abort |
| resume_pulse | output | 1 | One-cycle pulse when execution resumes |
| pwr_off_strobe | output | 1 | One-cycle power-down strobe after entry |
| pwr_on_strobe | output | 1 | One-cycle power-up strobe at exit start |

## Verification
The properties assume the following about the inputs:
- `wake` is a synchronous level, sampled at every rising edge.
- `req_state` is always below NUM_STATES.
- `prep_done` only has meaning during preparation.

The stimulus changes every input at the falling clock edge only. It indexes only the four table entries that exist. It raises `prep_done` only after it has seen `phase` 1. It also drives requests and wake-ups on purpose during idle and exit, so that the ignore rules are exercised.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;
  localparam int PHASE_W = 3;
  typedef enum logic [PHASE_W-1:0] {
    PH_EXEC  = 3'd0,
    PH_PREP  = 3'd1,
    PH_ENTRY = 3'd2,
    PH_IDLE  = 3'd3,
    PH_EXIT  = 3'd4
  } phase_t;
endpackage

// File: rtl/isq_cfg_table.sv
`timescale 1ns/1ps
// Per-state timing table: one register set per state, flat read mux.
module isq_cfg_table #(
  parameter int NUM_STATES = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_entry,
  input  logic [CNT_W-1:0] wr_exit,
  input  logic             wr_abortable,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_entry,
  output logic [CNT_W-1:0] rd_exit,
  output logic             rd_abortable
);
  logic [NUM_STATES*CNT_W-1:0] entry_flat;
  logic [NUM_STATES*CNT_W-1:0] exit_flat;
  logic [NUM_STATES-1:0]       abort_flat;

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_state
    logic [CNT_W-1:0] ent_q;
    logic [CNT_W-1:0] ext_q;
    logic             abt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= CNT_W'(1);
        ext_q <= CNT_W'(1);
        abt_q <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_q <= wr_entry;
        ext_q <= wr_exit;
        abt_q <= wr_abortable;
      end
    end
    assign entry_flat[g*CNT_W +: CNT_W] = ent_q;
    assign exit_flat[g*CNT_W +: CNT_W]  = ext_q;
    assign abort_flat[g]                = abt_q;
  end

  assign rd_entry     = entry_flat[rd_idx*CNT_W +: CNT_W];
  assign rd_exit      = exit_flat[rd_idx*CNT_W +: CNT_W];
  assign rd_abortable = abort_flat[rd_idx];
endmodule

// File: rtl/isq_span_timer.sv
`timescale 1ns/1ps
// Down counter for a phase span; last is high in the final cycle.
module isq_span_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && (cnt_q > CNT_W'(1))) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/isq_wake_hold.sv
`timescale 1ns/1ps
// Sticky record of a wake-up seen while entry cannot be interrupted.
module isq_wake_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= 1'b0;
    else if (clr) held <= 1'b0;
    else if (set) held <= 1'b1;
  end
endmodule

// File: rtl/cpu_idle_sequencer.sv
`timescale 1ns/1ps
module cpu_idle_sequencer #(
  parameter int NUM_STATES = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_state,
  input  logic             wake,
  input  logic             prep_done,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CNT_W-1:0] cfg_entry,
  input  logic [CNT_W-1:0] cfg_exit,
  input  logic             cfg_abortable,
  output logic [2:0]       phase,
  output logic             committed,
  output logic             flush_req,
  output logic             abort_pulse,
  output logic             resume_pulse,
  output logic             pwr_off_strobe,
  output logic             pwr_on_strobe
);
  import isq_pkg::*;

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] tbl_entry, tbl_exit;
  logic             tbl_abortable;
  logic [CNT_W-1:0] cap_entry_q, cap_exit_q;
  logic             tmr_load, tmr_step, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             wake_held, hold_set, hold_clr;
  logic             accept;
  logic             abort_d, resume_d, off_d, on_d;

  isq_cfg_table #(.NUM_STATES(NUM_STATES), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr), .wr_idx(cfg_idx), .wr_entry(cfg_entry),
    .wr_exit(cfg_exit), .wr_abortable(cfg_abortable),
    .rd_idx(req_state), .rd_entry(tbl_entry), .rd_exit(tbl_exit),
    .rd_abortable(tbl_abortable)
  );

  isq_span_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .step(tmr_step), .last(tmr_last)
  );

  isq_wake_hold u_hold (
    .clk(clk), .rst_n(rst_n), .set(hold_set), .clr(hold_clr), .held(wake_held)
  );

  assign accept   = req_valid && (phase_q == PH_EXEC);
  assign tmr_step = (phase_q == PH_ENTRY) || (phase_q == PH_EXIT);
  assign hold_set = (phase_q == PH_ENTRY) && wake;
  assign hold_clr = (phase_q == PH_ENTRY) && tmr_last;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = tbl_entry;
    abort_d  = 1'b0;
    resume_d = 1'b0;
    off_d    = 1'b0;
    on_d     = 1'b0;
    unique case (phase_q)
      PH_EXEC: begin
        if (req_valid) begin
          if (tbl_abortable) begin
            phase_d = PH_PREP;
          end else begin
            phase_d  = PH_ENTRY;
            tmr_load = 1'b1;
            tmr_val  = tbl_entry;
          end
        end
      end
      PH_PREP: begin
        if (wake) begin
          phase_d = PH_EXEC;
          abort_d = 1'b1;
        end else if (prep_done) begin
          phase_d  = PH_ENTRY;
          tmr_load = 1'b1;
          tmr_val  = cap_entry_q;
        end
      end
      PH_ENTRY: begin
        if (tmr_last) begin
          off_d = 1'b1;
          if (wake || wake_held) begin
            phase_d  = PH_EXIT;
            tmr_load = 1'b1;
            tmr_val  = cap_exit_q;
            on_d     = 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_IDLE: begin
        if (wake) begin
          phase_d  = PH_EXIT;
          tmr_load = 1'b1;
          tmr_val  = cap_exit_q;
          on_d     = 1'b1;
        end
      end
      PH_EXIT: begin
        if (tmr_last) begin
          phase_d  = PH_EXEC;
          resume_d = 1'b1;
        end
      end
      default: phase_d = PH_EXEC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q        <= PH_EXEC;
      cap_entry_q    <= '0;
      cap_exit_q     <= '0;
      abort_pulse    <= 1'b0;
      resume_pulse   <= 1'b0;
      pwr_off_strobe <= 1'b0;
      pwr_on_strobe  <= 1'b0;
    end else begin
      phase_q        <= phase_d;
      abort_pulse    <= abort_d;
      resume_pulse   <= resume_d;
      pwr_off_strobe <= off_d;
      pwr_on_strobe  <= on_d;
      if (accept) begin
        cap_entry_q <= tbl_entry;
        cap_exit_q  <= tbl_exit;
      end
    end
  end

  assign phase     = phase_q;
  assign req_ready = (phase_q == PH_EXEC);
  assign flush_req = (phase_q == PH_PREP);
  assign committed = (phase_q == PH_ENTRY) || (phase_q == PH_IDLE) ||
                     (phase_q == PH_EXIT);
endmodule

// File: rtl/isq_checker.sv
`timescale 1ns/1ps
module isq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       wake,
  input logic [2:0] phase,
  input logic       committed,
  input logic       abort_pulse,
  input logic       resume_pulse,
  input logic       pwr_on_strobe
);
  import isq_pkg::*;

  a_r2_accept_leaves_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && req_valid) |=> (phase == PH_PREP || phase == PH_ENTRY));

  a_r4_wake_aborts_prep: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PREP && wake) |=> (phase == PH_EXEC && abort_pulse));

  a_r5_entry_not_abortable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ENTRY) |=> (phase == PH_ENTRY || phase == PH_IDLE || phase == PH_EXIT));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !wake) |=> (phase == PH_IDLE));

  a_r8_resume_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (phase == PH_EXEC && $past(phase) == PH_EXIT));

  a_r9_commit_starts_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(committed) |-> (phase == PH_ENTRY));

  a_r10_on_strobe_in_exit: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_strobe |-> (phase == PH_EXIT));
endmodule

bind cpu_idle_sequencer isq_checker u_isq_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wake(wake),
  .phase(phase), .committed(committed), .abort_pulse(abort_pulse),
  .resume_pulse(resume_pulse), .pwr_on_strobe(pwr_on_strobe)
);

// File: tb/test_cpu_idle_sequencer.sv
`timescale 1ns/1ps
module test_cpu_idle_sequencer;
  localparam int NS = 4;
  localparam int CW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, wake, prep_done;
  logic [IW-1:0] req_state, cfg_idx;
  logic          cfg_wr, cfg_abortable;
  logic [CW-1:0] cfg_entry, cfg_exit;
  logic [2:0]    phase;
  logic          committed, flush_req, abort_pulse, resume_pulse;
  logic          pwr_off_strobe, pwr_on_strobe;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  cpu_idle_sequencer #(.NUM_STATES(NS), .CNT_W(CW)) i_cpu_idle_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_state(req_state), .wake(wake), .prep_done(prep_done),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
    .cfg_exit(cfg_exit), .cfg_abortable(cfg_abortable), .phase(phase),
    .committed(committed), .flush_req(flush_req), .abort_pulse(abort_pulse),
    .resume_pulse(resume_pulse), .pwr_off_strobe(pwr_off_strobe),
    .pwr_on_strobe(pwr_on_strobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic program_state(input int s, input int e, input int x, input bit ab);
    cfg_wr = 1'b1; cfg_idx = IW'(s); cfg_entry = CW'(e);
    cfg_exit = CW'(x); cfg_abortable = ab;
    tick();
    cfg_wr = 1'b0;
  endtask

  // prep_wait < 0: non-abortable state; wk < 0: no wake during entry
  task automatic run_seq(input int s, input int e, input int x, input int prep_wait,
                         input int wk, input bit rewrite);
    int cnt;
    check(req_ready == 1'b1, "R2 ready in execute", req_ready, 1);
    req_valid = 1'b1; req_state = IW'(s);
    tick();
    req_valid = 1'b0;
    if (prep_wait >= 0) begin
      check(phase == 3'd1 && flush_req, "R3 abortable enters preparation", phase, 1);
      for (int i = 0; i < prep_wait; i++) tick();
      check(phase == 3'd1, "R4 preparation waits for done", phase, 1);
      prep_done = 1'b1;
      tick();
      prep_done = 1'b0;
    end
    check(phase == 3'd2, "R3 R12 entry phase code", phase, 2);
    check(committed == 1'b1, "R9 committed in entry", committed, 1);
    cnt = 0;
    while (phase == 3'd2 && cnt < 100) begin
      cnt++;
      wake = (cnt - 1 == wk);
      cfg_wr = rewrite && (cnt == 1);
      cfg_idx = IW'(s); cfg_entry = CW'(e + 4); cfg_exit = CW'(x + 4);
      cfg_abortable = 1'b0;
      tick();
    end
    wake = 1'b0; cfg_wr = 1'b0;
    check(cnt == mx1(e), rewrite ? "R11 entry uses captured count" : "R5 entry length",
          cnt, mx1(e));
    check(pwr_off_strobe == 1'b1, "R10 power-off strobe after entry", pwr_off_strobe, 1);
    if (wk >= 0) begin
      check(phase == 3'd4, "R6 idle skipped after wake in entry", phase, 4);
    end else begin
      check(phase == 3'd3, "R7 R12 idle reached", phase, 3);
      for (int i = 0; i < 3; i++) begin
        req_valid = 1'b1;
        tick();
        check(phase == 3'd3 && !req_ready, "R2 R7 idle held, request ignored", phase, 3);
      end
      req_valid = 1'b0;
      wake = 1'b1;
      tick();
      wake = 1'b0;
      check(phase == 3'd4, "R7 wake leaves idle", phase, 4);
    end
    check(pwr_on_strobe == 1'b1, "R10 power-on strobe at exit", pwr_on_strobe, 1);
    cnt = 0;
    while (phase == 3'd4 && cnt < 100) begin
      cnt++;
      wake = 1'b1;
      tick();
    end
    wake = 1'b0;
    check(cnt == mx1(x), rewrite ? "R11 exit uses captured count" : "R8 exit length",
          cnt, mx1(x));
    check(phase == 3'd0 && resume_pulse, "R8 resume pulse at execute", resume_pulse, 1);
    check(committed == 1'b0, "R9 not committed in execute", committed, 0);
    tick();
    check(resume_pulse == 1'b0, "R8 resume pulse one cycle", resume_pulse, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_state = '0; wake = 1'b0; prep_done = 1'b0;
    cfg_wr = 1'b0; cfg_idx = '0; cfg_entry = '0; cfg_exit = '0; cfg_abortable = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(phase == 3'd0, "R1 R12 reset phase execute", phase, 0);
    check(req_ready && !committed && !flush_req, "R1 reset ready, not committed", req_ready, 1);
    check(!abort_pulse && !resume_pulse && !pwr_off_strobe && !pwr_on_strobe,
          "R1 reset pulses low", resume_pulse, 0);

    for (int e = 0; e < 6; e++)
      for (int x = 0; x < 6; x++) begin
        program_state((e + x) % NS, e, x, 1'b0);
        run_seq((e + x) % NS, e, x, -1, -1, 1'b0);
      end

    for (int e = 1; e < 6; e++)
      for (int w = 0; w < e; w++) begin
        program_state(w % NS, e, 2, 1'b0);
        run_seq(w % NS, e, 2, -1, w, 1'b0);
      end

    program_state(1, 4, 3, 1'b0);
    run_seq(1, 4, 3, -1, -1, 1'b1);

    for (int p = 0; p < 3; p++) begin
      program_state(2, p + 2, 3, 1'b1);
      run_seq(2, p + 2, 3, p, -1, 1'b0);
    end

    // abort from preparation, wake wins over prep_done
    for (int p = 0; p < 3; p++) begin
      program_state(3, 3, 2, 1'b1);
      req_valid = 1'b1; req_state = 2'd3;
      tick();
      req_valid = 1'b0;
      check(phase == 3'd1, "R3 abortable enters preparation", phase, 1);
      for (int i = 0; i < p; i++) tick();
      wake = 1'b1; prep_done = (p != 1);
      tick();
      wake = 1'b0; prep_done = 1'b0;
      check(phase == 3'd0 && abort_pulse, "R4 wake aborts preparation", phase, 0);
      check(!committed && !pwr_off_strobe, "R4 R9 abort never commits", committed, 0);
      tick();
      check(abort_pulse == 1'b0, "R4 abort pulse one cycle", abort_pulse, 0);
      check(phase == 3'd0 && req_ready, "R2 ready again after abort", phase, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule